// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit forms the memory operand address for an 8-bit processor with a 16-bit address space. Each request presents a decoded addressing-mode code, up to two operand bytes that followed the opcode, the index pair H:X, the stack pointer and the program counter. One clock later the unit presents the effective address and its valid flag. It also presents the post-increment value for H:X with a write strobe, a flag for the extra cycle that stack-relative modes spend on their prefix byte, and the branch target for relative branches.

All 16-bit sums wrap modulo 65536, and no carry is reported. The first operand byte (`op_b0`) is the single offset in the 8-bit modes and the high byte in the 16-bit modes. The second byte (`op_b1`) is the low byte. For relative branches, `pc` must hold the address of the byte that follows the branch's last operand byte. The outputs are registered behind a request enable (`en`). The address calculation does not stretch the instruction; only the stack-relative prefix costs a cycle.

Mode codes on `mode`:

| Code | Mode |
|------|------|
| 0 | inherent |
| 1 | direct |
| 2 | extended |
| 3 | H:X |
| 4 | H:X with post-increment |
| 5 | H:X plus unsigned byte |
| 6 | H:X plus unsigned byte, with post-increment |
| 7 | H:X plus 16-bit word |
| 8 | SP plus unsigned byte |
| 9 | SP plus 16-bit word |
| 10 | relative branch |
| 11 to 15 | unused |

Top module: `eag_top`

## Requirements
- R1: While reset is held, and until a request has been accepted after reset, `ea`, `hx_nxt` and `pc_nxt` read 0, and `ea_vld`, `extra_cyc`, `hx_we` and `pc_load` read 0.
- R2: Direct (code 1) gives `ea` = {0x00, op_b0} with `ea_vld`=1.
- R3: Extended (code 2) gives `ea` = {op_b0, op_b1} with `ea_vld`=1.
- R4: Codes 3 and 4 give `ea` = H:X. Code 4 also raises `hx_we` with `hx_nxt` = H:X+1, so 0xFFFF wraps to 0x0000.
- R5: Codes 5 and 6 give `ea` = H:X + zero-extended op_b0, wrapping. Code 6 also raises `hx_we` with `hx_nxt` = H:X+1.
- R6: Code 7 gives `ea` = H:X + {op_b0, op_b1}, wrapping.
- R7: Code 8 gives `ea` = SP + zero-extended op_b0, and code 9 gives `ea` = SP + {op_b0, op_b1}, both wrapping. `extra_cyc` is 1 for these two codes and 0 for every other code.
- R8: Relative (code 10) sets `ea_vld`=0. When `br_take`=1 it gives `pc_load`=1 and `pc_nxt` = pc + sign-extended op_b0. Otherwise it gives `pc_load`=0 and `pc_nxt` = pc.
- R9: Inherent (code 0) and the unused codes 11 to 15 give `ea_vld`=0, `hx_we`=0, `extra_cyc`=0, `pc_load`=0 and `ea`=0.
- R10: Outputs change on the clock edge that samples `en`=1. After an edge with `en`=0, all four flags read 0, and `ea`, `hx_nxt` and `pc_nxt` hold their previous values.
- R11: `hx_we` is raised only for codes 4 and 6. For any non-branch request that is accepted, `hx_nxt` equals H:X when no increment applies, and `pc_nxt` equals pc.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en | input | 1 | Request enable; the inputs below are sampled when high |
| mode | input | 4 | Addressing-mode code |
| op_b0 | input | 8 | First operand byte after the opcode |
| op_b1 | input | 8 | Second operand byte after the opcode |
| hx | input | 16 | Index pair H:X |
| sp | input | 16 | Stack pointer |
| pc | input | 16 | Address following the current instruction |
| br_take | input | 1 | Branch condition true |
| ea | output | 16 | Effective address |
| ea_vld | output | 1 | Effective address is meaningful |
| extra_cyc | output | 1 | Stack-relative prefix cycle needed |
| hx_nxt | output | 16 | Next value for H:X |
| hx_we | output | 1 | Commit `hx_nxt` to H:X |
| pc_nxt | output | 16 | Next program counter |
| pc_load | output | 1 | Branch taken; load `pc_nxt` |

## Verification
The checks assume that `en` is low for the whole reset and for the two synchronizer cycles after it, so that no request is lost and nothing is compared before the first accepted request. They also assume that `mode` takes only 4-bit values and that every request input is stable around the sampling edge. The stimulus drives all inputs on the falling clock edge and keeps `en` low until well after reset. It then applies directed cases for each code, including the wrap values 0xFFFF and the offsets 0x7F and 0x80. After that it sends a long stretch of random requests over all sixteen codes, with `en` toggled at random.

// File: rtl/eag_pkg.sv
package eag_pkg;
  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    MD_INH  = 4'd0,
    MD_DIR  = 4'd1,
    MD_EXT  = 4'd2,
    MD_IX   = 4'd3,
    MD_IXP  = 4'd4,
    MD_IX1  = 4'd5,
    MD_IX1P = 4'd6,
    MD_IX2  = 4'd7,
    MD_SP1  = 4'd8,
    MD_SP2  = 4'd9,
    MD_REL  = 4'd10
  } mode_e;

  typedef enum logic [1:0] {BS_ZERO, BS_HX, BS_SP, BS_PC} base_e;
  typedef enum logic [1:0] {OF_ZERO, OF_BYTE, OF_WORD, OF_SBYTE} off_e;

  typedef struct packed {
    base_e base;
    off_e  off;
    logic  addr_vld;
    logic  post_inc;
    logic  prefix;
    logic  branch;
  } ctl_t;
endpackage

// File: rtl/eag_decode.sv
module eag_decode
  import eag_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  output ctl_t              ctl
);
  always_comb begin
    ctl = '{base: BS_ZERO, off: OF_ZERO, addr_vld: 1'b0,
            post_inc: 1'b0, prefix: 1'b0, branch: 1'b0};
    case (mode)
      MD_DIR:  begin ctl.off = OF_BYTE; ctl.addr_vld = 1'b1; end
      MD_EXT:  begin ctl.off = OF_WORD; ctl.addr_vld = 1'b1; end
      MD_IX:   begin ctl.base = BS_HX; ctl.addr_vld = 1'b1; end
      MD_IXP:  begin ctl.base = BS_HX; ctl.addr_vld = 1'b1; ctl.post_inc = 1'b1; end
      MD_IX1:  begin ctl.base = BS_HX; ctl.off = OF_BYTE; ctl.addr_vld = 1'b1; end
      MD_IX1P: begin
        ctl.base = BS_HX; ctl.off = OF_BYTE; ctl.addr_vld = 1'b1; ctl.post_inc = 1'b1;
      end
      MD_IX2:  begin ctl.base = BS_HX; ctl.off = OF_WORD; ctl.addr_vld = 1'b1; end
      MD_SP1:  begin
        ctl.base = BS_SP; ctl.off = OF_BYTE; ctl.addr_vld = 1'b1; ctl.prefix = 1'b1;
      end
      MD_SP2:  begin
        ctl.base = BS_SP; ctl.off = OF_WORD; ctl.addr_vld = 1'b1; ctl.prefix = 1'b1;
      end
      MD_REL:  begin ctl.base = BS_PC; ctl.off = OF_SBYTE; ctl.branch = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/eag_add.sv
module eag_add #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum
);
  always_comb sum = a + b;
endmodule

// File: rtl/eag_top.sv
module eag_top
  import eag_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [MODE_W-1:0] mode,
  input  logic [DW-1:0]     op_b0,
  input  logic [DW-1:0]     op_b1,
  input  logic [2*DW-1:0]   hx,
  input  logic [2*DW-1:0]   sp,
  input  logic [2*DW-1:0]   pc,
  input  logic              br_take,
  output logic [2*DW-1:0]   ea,
  output logic              ea_vld,
  output logic              extra_cyc,
  output logic [2*DW-1:0]   hx_nxt,
  output logic              hx_we,
  output logic [2*DW-1:0]   pc_nxt,
  output logic              pc_load
);
  localparam int AW     = 2 * DW;
  localparam int N_ADD  = 2;
  localparam int RS_LEN = 2;

  logic [RS_LEN-1:0] rst_q;
  logic              rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= '0;
    else        rst_q <= {rst_q[RS_LEN-2:0], 1'b1};
  end
  assign rst_sync_n = rst_q[RS_LEN-1];

  ctl_t ctl;
  eag_decode u_dec (.mode(mode), .ctl(ctl));

  logic [AW-1:0] base_v, off_v;
  always_comb begin
    case (ctl.base)
      BS_HX:   base_v = hx;
      BS_SP:   base_v = sp;
      BS_PC:   base_v = pc;
      default: base_v = '0;
    endcase
    case (ctl.off)
      OF_BYTE:  off_v = {{DW{1'b0}}, op_b0};
      OF_WORD:  off_v = {op_b0, op_b1};
      OF_SBYTE: off_v = {{DW{op_b0[DW-1]}}, op_b0};
      default:  off_v = '0;
    endcase
  end

  logic [AW-1:0] add_a [N_ADD];
  logic [AW-1:0] add_b [N_ADD];
  logic [AW-1:0] add_s [N_ADD];
  assign add_a[0] = base_v;
  assign add_b[0] = off_v;
  assign add_a[1] = hx;
  assign add_b[1] = AW'(1);

  for (genvar g = 0; g < N_ADD; g++) begin : g_add
    eag_add #(.W(AW)) u_add (.a(add_a[g]), .b(add_b[g]), .sum(add_s[g]));
  end

  logic [AW-1:0] ea_d, hx_d, pc_d;
  logic          vld_d, pre_d, we_d, ld_d;
  always_comb begin
    ea_d  = ctl.addr_vld ? add_s[0] : '0;
    hx_d  = ctl.post_inc ? add_s[1] : hx;
    pc_d  = (ctl.branch && br_take) ? add_s[0] : pc;
    vld_d = en && ctl.addr_vld;
    pre_d = en && ctl.prefix;
    we_d  = en && ctl.post_inc;
    ld_d  = en && ctl.branch && br_take;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ea_vld    <= 1'b0;
      extra_cyc <= 1'b0;
      hx_we     <= 1'b0;
      pc_load   <= 1'b0;
    end else begin
      ea_vld    <= vld_d;
      extra_cyc <= pre_d;
      hx_we     <= we_d;
      pc_load   <= ld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ea     <= '0;
      hx_nxt <= '0;
      pc_nxt <= '0;
    end else if (en) begin
      ea     <= ea_d;
      hx_nxt <= hx_d;
      pc_nxt <= pc_d;
    end
  end
endmodule

// File: rtl/eag_chk.sv
module eag_chk #(
  parameter int DW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            en,
  input logic [3:0]      mode,
  input logic [DW-1:0]   op_b0,
  input logic [2*DW-1:0] hx,
  input logic [2*DW-1:0] pc,
  input logic [2*DW-1:0] ea,
  input logic            ea_vld,
  input logic            extra_cyc,
  input logic [2*DW-1:0] hx_nxt,
  input logic            hx_we,
  input logic [2*DW-1:0] pc_nxt,
  input logic            pc_load
);
  AST_DIR_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && $past(mode) == 4'd1 && ea_vld) |-> ea[2*DW-1:DW] == '0); // R2

  AST_HX_INC: assert property (@(posedge clk) disable iff (!rst_n)
    hx_we |-> hx_nxt == (2*DW)'($past(hx) + 1)); // R4

  AST_PREFIX_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    extra_cyc |-> (ea_vld && !hx_we && !pc_load)); // R7

  AST_REL_TGT: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> (!ea_vld && pc_nxt == (2*DW)'($past(pc) + {{DW{$past(op_b0[DW-1])}}, $past(op_b0)}))); // R8

  AST_IDLE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> !(ea_vld || extra_cyc || hx_we || pc_load)); // R10

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> ($stable(ea) && $stable(hx_nxt) && $stable(pc_nxt))); // R10

  AST_WE_MODES: assert property (@(posedge clk) disable iff (!rst_n)
    hx_we |-> ($past(mode) == 4'd4 || $past(mode) == 4'd6)); // R11
endmodule

bind eag_top eag_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .op_b0(op_b0),
  .hx(hx), .pc(pc), .ea(ea), .ea_vld(ea_vld), .extra_cyc(extra_cyc),
  .hx_nxt(hx_nxt), .hx_we(hx_we), .pc_nxt(pc_nxt), .pc_load(pc_load)
);

// File: tb/tb_eag_top.sv
module tb_eag_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [3:0]  mode = '0;
  logic [7:0]  op_b0 = '0, op_b1 = '0;
  logic [15:0] hx = '0, sp = '0, pc = '0;
  logic        br_take = 1'b0;
  logic [15:0] ea, hx_nxt, pc_nxt;
  logic        ea_vld, extra_cyc, hx_we, pc_load;

  int checks = 0;
  int errors = 0;

  eag_top dut (
    .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .op_b0(op_b0), .op_b1(op_b1),
    .hx(hx), .sp(sp), .pc(pc), .br_take(br_take), .ea(ea), .ea_vld(ea_vld),
    .extra_cyc(extra_cyc), .hx_nxt(hx_nxt), .hx_we(hx_we), .pc_nxt(pc_nxt),
    .pc_load(pc_load)
  );

  always #2.5 clk = ~clk;

  // reference model, one request per rising edge
  logic [15:0] m_ea = '0, m_hx = '0, m_pc = '0;
  logic        m_vld = 1'b0, m_ext = 1'b0, m_we = 1'b0, m_ld = 1'b0;
  string       m_req = "R1";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ea = '0; m_hx = '0; m_pc = '0;
      m_vld = 0; m_ext = 0; m_we = 0; m_ld = 0; m_req = "R1";
    end else begin
      m_vld = 0; m_ext = 0; m_we = 0; m_ld = 0;
      if (!en) m_req = "R10";
      else begin
        m_hx = hx; m_pc = pc; m_ea = '0;
        case (int'(mode))
          1:  begin m_ea = 16'(op_b0); m_vld = 1; m_req = "R2"; end
          2:  begin m_ea = {op_b0, op_b1}; m_vld = 1; m_req = "R3"; end
          3:  begin m_ea = hx; m_vld = 1; m_req = "R4"; end
          4:  begin m_ea = hx; m_vld = 1; m_we = 1; m_hx = hx + 16'd1; m_req = "R4"; end
          5:  begin m_ea = hx + 16'(op_b0); m_vld = 1; m_req = "R5"; end
          6:  begin m_ea = hx + 16'(op_b0); m_vld = 1; m_we = 1; m_hx = hx + 16'd1; m_req = "R5"; end
          7:  begin m_ea = hx + {op_b0, op_b1}; m_vld = 1; m_req = "R6"; end
          8:  begin m_ea = sp + 16'(op_b0); m_vld = 1; m_ext = 1; m_req = "R7"; end
          9:  begin m_ea = sp + {op_b0, op_b1}; m_vld = 1; m_ext = 1; m_req = "R7"; end
          10: begin
            m_req = "R8";
            if (br_take) begin
              m_ld = 1;
              m_pc = 16'(int'(pc) + int'($signed(op_b0)));
            end
          end
          default: m_req = "R9";
        endcase
      end
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp,
                     input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    chk(m_req, 16'(ea_vld), 16'(m_vld), "ea_vld");
    chk(m_req, 16'(extra_cyc), 16'(m_ext), "extra_cyc");
    chk(m_req == "R4" || m_req == "R5" ? m_req : "R11", 16'(hx_we), 16'(m_we), "hx_we");
    chk(m_req, 16'(pc_load), 16'(m_ld), "pc_load");
    chk(m_req, ea, m_ea, "ea");
    chk(m_req == "R10" ? m_req : "R11", hx_nxt, m_hx, "hx_nxt");
    chk(m_req == "R8" || m_req == "R10" ? m_req : "R11", pc_nxt, m_pc, "pc_nxt");
  endtask

  always @(negedge clk) if (rst_n) compare();

  task automatic req(input int md, input logic [7:0] b0, input logic [7:0] b1,
                     input logic [15:0] h, input logic [15:0] s, input logic [15:0] p,
                     input logic t);
    @(negedge clk);
    en = 1; mode = 4'(md); op_b0 = b0; op_b1 = b1; hx = h; sp = s; pc = p; br_take = t;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      en = 0; mode = 4'($urandom_range(0, 15)); op_b0 = 8'($urandom); hx = 16'($urandom);
      pc = 16'($urandom);
    end
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", {ea_vld, extra_cyc, hx_we, pc_load}, '0, "flags in reset");
    chk("R1", ea | hx_nxt | pc_nxt, '0, "data in reset");
    rst_n = 1;
    idle(5);
    req(1, 8'h55, 8'h00, 16'h1234, 16'h0100, 16'h2000, 0);   // R2
    req(1, 8'hFF, 8'hAA, 16'hFFFF, 16'h0100, 16'h2000, 0);   // R2 top of page
    req(2, 8'hF0, 8'h3B, 16'h0000, 16'h0100, 16'h2000, 0);   // R3
    req(3, 8'h00, 8'h00, 16'hC000, 16'h0100, 16'h2000, 0);   // R4
    req(4, 8'h00, 8'h00, 16'hFFFF, 16'h0100, 16'h2000, 0);   // R4 wrap
    req(5, 8'hFF, 8'h00, 16'hFF80, 16'h0100, 16'h2000, 0);   // R5 wrap
    req(6, 8'h10, 8'h00, 16'h00FF, 16'h0100, 16'h2000, 0);   // R5 post-inc
    req(7, 8'hFF, 8'hFF, 16'h0002, 16'h0100, 16'h2000, 0);   // R6 wrap
    req(8, 8'h80, 8'h00, 16'h0000, 16'hFFF0, 16'h2000, 0);   // R7
    req(9, 8'h12, 8'h34, 16'h0000, 16'h1000, 16'h2000, 0);   // R7
    req(10, 8'h7F, 8'h00, 16'h0000, 16'h0100, 16'hFFF0, 1);  // R8 forward wrap
    req(10, 8'h80, 8'h00, 16'h0000, 16'h0100, 16'h0010, 1);  // R8 backward wrap
    req(10, 8'h80, 8'h00, 16'h0000, 16'h0100, 16'h4000, 0);  // R8 not taken
    req(0, 8'h12, 8'h34, 16'h5555, 16'h0100, 16'h4000, 1);   // R9 inherent
    req(13, 8'h12, 8'h34, 16'h5555, 16'h0100, 16'h4000, 1);  // R9 unused code
    req(4, 8'h00, 8'h00, 16'h0041, 16'h0100, 16'h4000, 0);   // R10 then hold
    idle(3);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      en = ($urandom_range(0, 3) != 0);
      mode = 4'($urandom); op_b0 = 8'($urandom); op_b1 = 8'($urandom);
      hx = 16'($urandom); sp = 16'($urandom); pc = 16'($urandom);
      br_take = 1'($urandom);
    end
    idle(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule